// File: doc/BRIEF.md
# Two-Level Interrupt Cause Controller

The block collects hardware interrupt events in three 32-bit cause groups (receive, transmit, miscellaneous) and folds them into a single interrupt line. Each group keeps a pending cause word, a mask, and a per-bit choice of how software acknowledges a pending bit: by writing a 1 to it, or simply by reading the cause word. Software can also force cause bits pending through a set register and can read the current mask back.

Above the groups sits a three-bit summary word, one bit per group, which records that the group had any unmasked pending cause. The summary word is acknowledged by reading it. A separate summary mask decides which group bits may drive the interrupt output. A driver typically reads the summary word, visits the flagged groups, acknowledges their causes, and adjusts the group masks.

Access is through a simple single-cycle register port: a request with a write enable, a word address, write data, and combinational read data that is valid in the same cycle as the request.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every group mask and the summary mask read all ones, every cause word and every clear-mode word read zero, the summary word reads zero and irq_o is low.
- R2: A 1 on any bit of a group's event input, or a write of 1s to the group's set register (offset 1), makes those cause bits pending from the next cycle.
- R3: Writing 1s to a group's mask-set register (offset 2) masks those bits and writing 1s to its mask-clear register (offset 3) unmasks them; 0 bits in either write leave the mask unchanged; the mask reads back at offset 5.
- R4: For a cause bit whose clear-mode bit (offset 4) is 0, writing 1 to that bit of the cause word (offset 0) clears it; for a bit whose clear-mode bit is 1, such a write has no effect.
- R5: Reading the cause word returns its value before the read; the read clears exactly those pending bits whose clear-mode bit is 1, and leaves the others.
- R6: A hardware event on a bit in the same cycle as a clear of that bit leaves the bit pending.
- R7: Summary bit 0 (receive), 1 (transmit) and 2 (misc) becomes set in the cycle after its group has any pending bit that is not masked, and stays set until the summary word is read; the read returns the value before the read and clears it, unless the group is still pending in that cycle.
- R8: irq_o is high exactly when some summary bit is set and the summary-mask bit at the same position is 0.
- R9: The word address is 5 bits: bits 4:3 select receive (0), transmit (1), misc (2) or the summary region (3), bits 2:0 the offset; the summary word is at 0x18, the summary mask (read/write) at 0x19; unused offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| rx_evt_i | input | 32 | Receive group event pulses |
| tx_evt_i | input | 32 | Transmit group event pulses |
| misc_evt_i | input | 32 | Misc group event pulses |
| irq_o | output | 1 | Interrupt output |

## Verification
The properties assume that at most one register access arrives per cycle and that the address and write-enable are stable for the whole request cycle; they also assume the event inputs carry known values whenever reset is released. The stimulus drives every input once per cycle on the falling edge, keeps events sparse so that masks and acknowledgements get a chance to act, and mixes random accesses over the full map, including unused offsets, with directed collisions between events and clears.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NGRP   = 3;
  localparam int OFS_W  = 3;
  localparam int GRP_W  = 2;
  localparam int ADDR_W = OFS_W + GRP_W;

  localparam logic [OFS_W-1:0] OFS_CAUSE = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SET   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_MSET  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_MCLR  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MODE  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_MVAL  = 3'd5;

  localparam logic [GRP_W-1:0] SUM_REGION = 2'd3;
  localparam logic [OFS_W-1:0] OFS_SUM    = 3'd0;
  localparam logic [OFS_W-1:0] OFS_SMASK  = 3'd1;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group
  import irq_ctrl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    evt_i,
  output logic [DW-1:0]    rdata_o,
  output logic             pend_o,
  output logic [DW-1:0]    cause_o,
  output logic [DW-1:0]    mask_o,
  output logic [DW-1:0]    mode_o
);
  logic [DW-1:0] cause_q, mask_q, mode_q;
  logic [DW-1:0] clr_bits, set_bits, mset_bits, mclr_bits;
  logic wr, rd;

  assign wr = sel_i & we_i;
  assign rd = sel_i & ~we_i;

  always_comb begin
    clr_bits  = '0;
    set_bits  = '0;
    mset_bits = '0;
    mclr_bits = '0;
    if (wr && ofs_i == OFS_CAUSE) clr_bits = wdata_i & ~mode_q;
    if (rd && ofs_i == OFS_CAUSE) clr_bits = mode_q;
    if (wr && ofs_i == OFS_SET)   set_bits  = wdata_i;
    if (wr && ofs_i == OFS_MSET)  mset_bits = wdata_i;
    if (wr && ofs_i == OFS_MCLR)  mclr_bits = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      // set sources dominate the clear
      cause_q <= (cause_q & ~clr_bits) | evt_i | set_bits;
      mask_q  <= (mask_q | mset_bits) & ~mclr_bits;
      if (wr && ofs_i == OFS_MODE) mode_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (ofs_i)
      OFS_CAUSE: rdata_o = cause_q;
      OFS_MODE:  rdata_o = mode_q;
      OFS_MVAL:  rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign pend_o  = |(cause_q & ~mask_q);
  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_ctrl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NGRP-1:0] pend_i,
  input  logic            rd_sum_i,
  input  logic            wr_smask_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NGRP-1:0] sum_o,
  output logic [DW-1:0]   smask_o,
  output logic            irq_o
);
  logic [NGRP-1:0] sum_q;
  logic [DW-1:0]   smask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      sum_q <= (rd_sum_i ? '0 : sum_q) | pend_i;
      if (wr_smask_i) smask_q <= wdata_i;
    end
  end

  assign sum_o   = sum_q;
  assign smask_o = smask_q;
  assign irq_o   = |(sum_q & ~smask_q[NGRP-1:0]);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     rx_evt_i,
  input  logic [DW-1:0]     tx_evt_i,
  input  logic [DW-1:0]     misc_evt_i,
  output logic              irq_o
);
  logic [GRP_W-1:0] region;
  logic [OFS_W-1:0] ofs;
  logic [NGRP-1:0][DW-1:0] grp_evt, grp_rdata, grp_cause, grp_mask, grp_mode;
  logic [NGRP-1:0] grp_sel, grp_pend, sum_bits;
  logic [DW-1:0] smask;
  logic sum_sel, rd_sum, wr_smask;

  assign region = addr_i[ADDR_W-1:OFS_W];
  assign ofs    = addr_i[OFS_W-1:0];
  assign grp_evt[0] = rx_evt_i;
  assign grp_evt[1] = tx_evt_i;
  assign grp_evt[2] = misc_evt_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_sel[g] = req_i && (region == GRP_W'(g));
    irq_cause_group #(.DW(DW)) i_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (grp_sel[g]),
      .we_i    (we_i),
      .ofs_i   (ofs),
      .wdata_i (wdata_i),
      .evt_i   (grp_evt[g]),
      .rdata_o (grp_rdata[g]),
      .pend_o  (grp_pend[g]),
      .cause_o (grp_cause[g]),
      .mask_o  (grp_mask[g]),
      .mode_o  (grp_mode[g])
    );
  end

  assign sum_sel  = req_i && (region == SUM_REGION);
  assign rd_sum   = sum_sel && !we_i && (ofs == OFS_SUM);
  assign wr_smask = sum_sel && we_i && (ofs == OFS_SMASK);

  irq_summary #(.DW(DW)) i_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (grp_pend),
    .rd_sum_i   (rd_sum),
    .wr_smask_i (wr_smask),
    .wdata_i    (wdata_i),
    .sum_o      (sum_bits),
    .smask_o    (smask),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < NGRP; g++)
      if (grp_sel[g]) rdata_o = grp_rdata[g];
    if (sum_sel) begin
      if (ofs == OFS_SUM)   rdata_o = DW'(sum_bits);
      if (ofs == OFS_SMASK) rdata_o = smask;
    end
  end
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DW-1:0]           wdata_i,
  input logic [DW-1:0]           rx_evt_i,
  input logic                    irq_o,
  input logic [NGRP-1:0][DW-1:0] grp_cause,
  input logic [NGRP-1:0][DW-1:0] grp_mask,
  input logic [NGRP-1:0][DW-1:0] grp_mode,
  input logic [NGRP-1:0]         sum_bits
);
  localparam logic [ADDR_W-1:0] RX_CAUSE = {2'd0, OFS_CAUSE};
  localparam logic [ADDR_W-1:0] RX_MSET  = {2'd0, OFS_MSET};

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_evt_i) |=> ((grp_cause[0] & $past(rx_evt_i)) == $past(rx_evt_i)));

  a_r3_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == RX_MSET)
      |=> ((grp_mask[0] & $past(wdata_i)) == $past(wdata_i)));

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RX_CAUSE && rx_evt_i == '0)
      |=> ((grp_cause[0] & $past(grp_mode[0])) == '0));

  a_r7_summary_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(grp_cause[0] & ~grp_mask[0])) |=> sum_bits[0]);

  a_r8_quiet_without_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_bits == '0) |-> !irq_o);
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rx_evt_i  (rx_evt_i),
  .irq_o     (irq_o),
  .grp_cause (grp_cause),
  .grp_mask  (grp_mask),
  .grp_mode  (grp_mode),
  .sum_bits  (sum_bits)
);

// File: tb/test_irq_cause_ctrl.sv
module test_irq_cause_ctrl;
  logic clk = 0, rst_ni = 0, req = 0, we = 0, irq;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata, ev_rx = '0, ev_tx = '0, ev_misc = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_cause [3], m_mask [3], m_mode [3], m_smask;
  logic [2:0]  m_sum;

  always #10 clk = ~clk;

  irq_cause_ctrl i_irq_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_evt_i(ev_rx), .tx_evt_i(ev_tx),
    .misc_evt_i(ev_misc), .irq_o(irq)
  );

  function automatic logic [31:0] model_read(logic [4:0] a);
    if (a[4:3] != 2'd3) begin
      case (a[2:0])
        3'd0: return m_cause[a[4:3]];
        3'd4: return m_mode[a[4:3]];
        3'd5: return m_mask[a[4:3]];
        default: return '0;
      endcase
    end
    if (a[2:0] == 3'd0) return {29'd0, m_sum};
    if (a[2:0] == 3'd1) return m_smask;
    return '0;
  endfunction

  function automatic logic model_irq();
    return |(m_sum & ~m_smask[2:0]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic w, logic [4:0] a, logic [31:0] d,
                      logic [31:0] e0, logic [31:0] e1, logic [31:0] e2, string tag);
    logic [31:0] ev [3];
    logic [2:0] pend;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; ev_rx = e0; ev_tx = e1; ev_misc = e2;
    ev[0] = e0; ev[1] = e1; ev[2] = e2;
    #1;
    check("R8 irq", {31'd0, irq}, {31'd0, model_irq()});
    if (r && !w) check(tag, rdata, model_read(a));
    @(posedge clk);
    for (int g = 0; g < 3; g++) pend[g] = |(m_cause[g] & ~m_mask[g]);
    for (int g = 0; g < 3; g++) begin
      logic sel;
      logic [31:0] clr, setv;
      sel = r && a[4:3] == 2'(g);
      clr = '0; setv = '0;
      if (sel && w && a[2:0] == 3'd0) clr = d & ~m_mode[g];
      if (sel && !w && a[2:0] == 3'd0) clr = m_mode[g];
      if (sel && w && a[2:0] == 3'd1) setv = d;
      m_cause[g] = (m_cause[g] & ~clr) | ev[g] | setv;
      if (sel && w && a[2:0] == 3'd2) m_mask[g] = m_mask[g] | d;
      if (sel && w && a[2:0] == 3'd3) m_mask[g] = m_mask[g] & ~d;
      if (sel && w && a[2:0] == 3'd4) m_mode[g] = d;
    end
    m_sum = ((r && !w && a == 5'h18) ? 3'd0 : m_sum) | pend;
    if (r && w && a == 5'h19) m_smask = d;
  endtask

  task automatic rd(logic [4:0] a, string tag);
    step(1, 0, a, '0, '0, '0, '0, tag);
  endtask
  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    step(1, 1, a, d, '0, '0, '0, tag);
  endtask
  task automatic idle();
    step(0, 0, '0, '0, '0, '0, '0, "idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset values come from the requirement, not the design
    for (int g = 0; g < 3; g++) begin
      m_cause[g] = '0; m_mask[g] = '1; m_mode[g] = '0;
    end
    m_sum = '0; m_smask = '1;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    for (int g = 0; g < 3; g++) begin
      rd({2'(g), 3'd0}, "R1 cause reset");
      rd({2'(g), 3'd4}, "R1 mode reset");
      rd({2'(g), 3'd5}, "R1 mask reset");
    end
    rd(5'h18, "R1 summary reset");
    rd(5'h19, "R1 summary mask reset");

    // R2 event and software set
    step(0, 0, '0, '0, 32'h8, '0, '0, "R2");
    rd(5'h00, "R2 event pending");
    wr(5'h09, 32'h100, "R2");
    rd(5'h08, "R2 software set");

    // R3 mask set / clear, zero bits untouched
    wr(5'h03, 32'h0000_000f, "R3");
    rd(5'h05, "R3 mask clear");
    wr(5'h02, 32'h0000_0001, "R3");
    wr(5'h03, 32'h0, "R3");
    rd(5'h05, "R3 mask set");

    // R7 R8: rx bit3 unmasked and pending
    wr(5'h19, ~32'h7, "R8");
    idle();
    check("R8 irq asserted", {31'd0, irq}, 32'd1);
    rd(5'h18, "R7 summary pre-clear value");

    // R4 write-1-to-clear, and ignored when in read-clear mode
    wr(5'h00, 32'h8, "R4");
    rd(5'h00, "R4 w1c cleared");
    wr(5'h14, 32'h20, "R4");
    wr(5'h11, 32'h21, "R4");
    wr(5'h10, 32'h21, "R4");
    rd(5'h14, "R4 mode readback");
    wr(5'h00, 32'h0, "R4");

    // R5 read-clear returns old value and clears only mode bits
    rd(5'h10, "R5 read returns pending");
    rd(5'h10, "R5 read cleared mode bits");

    // R6 event collides with clear
    step(0, 0, '0, '0, 32'h40, '0, '0, "R6");
    step(1, 1, 5'h00, 32'h40, 32'h40, '0, '0, "R6");
    rd(5'h00, "R6 event wins over w1c");
    wr(5'h04, 32'h80, "R6");
    wr(5'h01, 32'h80, "R6");
    step(1, 0, 5'h00, '0, 32'h80, '0, '0, "R6 read collision");
    rd(5'h00, "R6 event wins over read-clear");

    // R7 summary clears on read once group is quiet
    wr(5'h02, 32'hffff_ffff, "R7");
    idle();
    rd(5'h18, "R7 summary still held");
    rd(5'h18, "R7 summary cleared by read");
    idle();
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R9 unused offsets
    wr(5'h06, 32'hffff_ffff, "R9");
    rd(5'h06, "R9 unused offset reads zero");
    rd(5'h1a, "R9 unused summary offset");

    // random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [31:0] d, e [3];
      int k;
      k = $urandom % 12;
      a = {2'($urandom % 4), 3'($urandom % 8)};
      if (k < 3) a = {2'($urandom % 3), 3'd0};
      else if (k == 3) a = 5'h18;
      d = $urandom;
      if ($urandom % 3 == 0) d = $urandom & $urandom & $urandom;
      for (int g = 0; g < 3; g++)
        e[g] = ($urandom % 5 == 0) ? ($urandom & $urandom & $urandom) : '0;
      step($urandom % 4 != 0, $urandom % 2 == 0, a, d, e[0], e[1], e[2],
           "R9 random access");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule